// File: doc/BRIEF.md
# Indexed Chipset Configuration Register File

This block keeps the setup registers of a 386-class core-logic chipset. Software reaches them through two I/O ports. A write to the index port selects a register number. A write to the data port then stores into that register, passing only the bits that register allows to be written. A read of the data port returns the selected register. The selection stays in place, so any number of data accesses can follow a single index write.

The contents of all thirteen registers are driven out as one flat vector to the decode logic next to the block. Writes to the four registers that control shadow-memory steering also raise a one-clock update pulse. The neighbouring logic uses that pulse to rebuild its memory map. The block does no bus-cycle timing and no memory steering of its own. An access is one clock with `io_wr` or `io_rd` high.

Top module: `cfgreg_bank`

## Requirements
- R1: A write at I/O address 0x22 loads the full 8-bit data value into the index latch. The latch is 0x00 after reset. It changes on nothing except a write at 0x22, so data accesses leave it unchanged.
- R2: A write at I/O address 0x24 stores the data, masked, into the register selected by the index. The new value is visible on `cfg_regs` and through readback from the next clock.
- R3: Writable-bit masks: index 0x20 keeps 0x3F, index 0x21 keeps 0xF3, index 0x29 keeps 0x0F, and indices 0x22–0x28 and 0x2A–0x2C take all eight bits. Bits outside the mask are stored as zero.
- R4: After reset, index 0x22 holds 0xF0, index 0x23 holds 0x40, index 0x28 holds 0x08 and index 0x29 holds 0xA0. Every other register holds 0x00.
- R5: `io_rdata` returns the selected register while `io_rd` is high with address 0x24. In every other case it is 0xFF, including a read at 0x22 and no read at all.
- R6: With an index outside 0x20–0x2C, a data write changes no register and a data read returns 0x00.
- R7: `map_update` is high for exactly the one clock after a data write to index 0x23, 0x24, 0x25 or 0x26. Data writes to other indices, including 0x27, and index writes never raise it.
- R8: The register at index 0x20+k sits on `cfg_regs[8k+7:8k]`, for k = 0 to 12.
- R9: Writes at any I/O address other than 0x22 and 0x24 change neither the index nor any register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | I/O address of the current access |
| io_wr | input | 1 | I/O write qualifier, one clock per access |
| io_rd | input | 1 | I/O read qualifier |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data. 0xFF when the access is not a data-port read |
| cfg_regs | output | 104 | All register contents, index 0x20 in the low byte |
| map_update | output | 1 | One-clock pulse after a write to a memory-map register |

## Verification
On every cycle the assertions check four things:
- The index latch holds unless the index port is written.
- No register moves without a data write to an implemented index.
- The update pulse is always preceded by a data write.
- Idle readback is 0xFF, and the upper bits of index 0x20 stay clear after a write.

Some behaviour only the bench scenarios can show:
- The exact mask applied at each index.
- The reset defaults, including 0xA0 at index 0x29, which lies outside that register's write mask.
- That 0x27 gives no update pulse while 0x23–0x26 do.
- That a stray address or an out-of-range index leaves all the state untouched.

// File: rtl/cfgreg_pkg.sv
package cfgreg_pkg;

    localparam int unsigned REG_COUNT = 13;
    localparam logic [7:0]  REG_BASE  = 8'h20;
    localparam logic [7:0]  COUNT8    = 8'(REG_COUNT);

    typedef logic [REG_COUNT-1:0][7:0] regfile_t;

    typedef struct packed {
        logic [7:0] index;
        regfile_t   regs;
        logic       map_upd;
    } state_t;

    function automatic logic [7:0] wr_mask(input int unsigned off);
        case (off)
            0:       return 8'h3F;
            1:       return 8'hF3;
            9:       return 8'h0F;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic logic [7:0] rst_val(input int unsigned off);
        case (off)
            2:       return 8'hF0;
            3:       return 8'h40;
            8:       return 8'h08;
            9:       return 8'hA0;
            default: return 8'h00;
        endcase
    endfunction

    function automatic regfile_t rst_file();
        regfile_t f;
        for (int k = 0; k < REG_COUNT; k++) f[k] = rst_val(k);
        return f;
    endfunction

    function automatic logic is_map_ctl(input logic [7:0] off);
        return (off >= 8'd3) && (off <= 8'd6);
    endfunction

endpackage

// File: rtl/cfgreg_io_decode.sv
module cfgreg_io_decode #(
    parameter int unsigned       ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] INDEX_PORT = 16'h0022,
    parameter logic [ADDR_W-1:0] DATA_PORT  = 16'h0024
) (
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    output logic              idx_we,
    output logic              dat_we,
    output logic              dat_re
);
    logic at_index;
    logic at_data;

    always_comb begin
        at_index = (io_addr == INDEX_PORT);
        at_data  = (io_addr == DATA_PORT);
        idx_we   = io_wr & at_index;
        dat_we   = io_wr & at_data;
        dat_re   = io_rd & at_data;
    end
endmodule

// File: rtl/cfgreg_store.sv
module cfgreg_store
    import cfgreg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_we,
    input  logic       dat_we,
    input  logic [7:0] wdata,
    output logic [7:0] index_q,
    output regfile_t   regs_q,
    output logic       map_upd_q
);
    state_t     st_d, st_q;
    logic [7:0] off;
    logic       hit;

    always_comb begin
        off  = st_q.index - REG_BASE;
        hit  = (st_q.index >= REG_BASE) && (off < COUNT8);
        st_d = st_q;
        st_d.map_upd = 1'b0;
        if (idx_we) st_d.index = wdata;
        if (dat_we && hit) begin
            for (int k = 0; k < REG_COUNT; k++) begin
                if (off == 8'(k)) st_d.regs[k] = wdata & wr_mask(k);
            end
            st_d.map_upd = is_map_ctl(off);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.index   <= 8'h00;
            st_q.regs    <= rst_file();
            st_q.map_upd <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign index_q   = st_q.index;
    assign regs_q    = st_q.regs;
    assign map_upd_q = st_q.map_upd;

    // R1
    index_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !idx_we |=> $stable(index_q));

    // R6
    regs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(dat_we && hit) |=> $stable(regs_q));

    // R7
    upd_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        map_upd_q |-> $past(dat_we));

    // R3
    mask_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_we && hit && off == 8'd0) |=> regs_q[0][7:6] == 2'b00);
endmodule

// File: rtl/cfgreg_readback.sv
module cfgreg_readback
    import cfgreg_pkg::*;
(
    input  logic       dat_re,
    input  logic [7:0] index,
    input  regfile_t   regs,
    output logic [7:0] rdata
);
    logic [7:0] off;
    logic [7:0] sel;

    always_comb begin
        off = index - REG_BASE;
        sel = 8'h00;
        if (index >= REG_BASE) begin
            for (int k = 0; k < REG_COUNT; k++) begin
                if (off == 8'(k)) sel = regs[k];
            end
        end
        rdata = dat_re ? sel : 8'hFF;
    end
endmodule

// File: rtl/cfgreg_bank.sv
module cfgreg_bank
    import cfgreg_pkg::*;
#(
    parameter int unsigned       ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] INDEX_PORT = 16'h0022,
    parameter logic [ADDR_W-1:0] DATA_PORT  = 16'h0024,
    localparam int unsigned      FLAT_W     = 8 * REG_COUNT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    output logic [FLAT_W-1:0] cfg_regs,
    output logic              map_update
);
    logic       idx_we, dat_we, dat_re;
    logic [7:0] index_q;
    regfile_t   regs_q;

    cfgreg_io_decode #(
        .ADDR_W(ADDR_W), .INDEX_PORT(INDEX_PORT), .DATA_PORT(DATA_PORT)
    ) u_dec (
        .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .idx_we(idx_we), .dat_we(dat_we), .dat_re(dat_re)
    );

    cfgreg_store u_store (
        .clk(clk), .rst_n(rst_n), .idx_we(idx_we), .dat_we(dat_we),
        .wdata(io_wdata), .index_q(index_q), .regs_q(regs_q),
        .map_upd_q(map_update)
    );

    cfgreg_readback u_rb (
        .dat_re(dat_re), .index(index_q), .regs(regs_q), .rdata(io_rdata)
    );

    // R8: register k occupies byte lane k
    generate
        for (genvar k = 0; k < REG_COUNT; k++) begin : g_lane
            assign cfg_regs[8*k +: 8] = regs_q[k];
        end
    endgenerate

    // R5
    rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !io_rd |-> io_rdata == 8'hFF);
endmodule

// File: tb/cfgreg_bank_bench.sv
`timescale 1ns/1ps
module cfgreg_bank_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [15:0]  io_addr = 16'h0;
    logic         io_wr = 1'b0;
    logic         io_rd = 1'b0;
    logic [7:0]   io_wdata = 8'h0;
    logic [7:0]   io_rdata;
    logic [103:0] cfg_regs;
    logic         map_update;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    cfgreg_bank u_cfgreg_bank (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
        .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .cfg_regs(cfg_regs), .map_update(map_update)
    );

    // {index, write data, expected readback, expected strobe}
    localparam logic [31:0] VEC [10] = '{
        32'h20_FF_3F_00, 32'h21_FF_F3_00, 32'h29_FF_0F_00, 32'h23_5A_5A_01,
        32'h26_A5_A5_01, 32'h27_FF_FF_00, 32'h2C_C3_C3_00, 32'h24_3C_3C_01,
        32'h30_77_00_00, 32'h1F_12_00_00
    };

    function automatic logic [7:0] dflt(input int off);
        case (off)
            2: return 8'hF0;
            3: return 8'h40;
            8: return 8'h08;
            9: return 8'hA0;
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic put(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0; io_addr = 16'h0;
    endtask

    task automatic get(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        #1 d = io_rdata;
        io_rd = 1'b0; io_addr = 16'h0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: got 00 expected 01");
        finish_run();
    end

    initial begin
        logic [7:0]   rd;
        logic [103:0] snap;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R4, R8: reset defaults on the flat output
        for (int k = 0; k < 13; k++) check("R4/R8 reset lane", cfg_regs[8*k +: 8], dflt(k));
        check("R7 no strobe at reset", {7'b0, map_update}, 8'h00);
        // R1: index resets to 0x00, out of range, so R6 readback 0x00
        get(16'h0024, rd); check("R1/R6 reset index read", rd, 8'h00);
        // R4 via readback
        for (int k = 0; k < 13; k++) begin
            put(16'h0022, 8'(8'h20 + k));
            get(16'h0024, rd); check("R4 reset readback", rd, dflt(k));
        end

        // vector walk: R2, R3, R6, R7
        foreach (VEC[i]) begin
            snap = cfg_regs;
            put(16'h0022, VEC[i][31:24]);
            check("R7 index write no strobe", {7'b0, map_update}, 8'h00);
            put(16'h0024, VEC[i][23:16]);
            check("R7 strobe", {7'b0, map_update}, VEC[i][7:0]);
            @(negedge clk);
            check("R7 strobe one clock", {7'b0, map_update}, 8'h00);
            get(16'h0024, rd); check("R2/R3 readback", rd, VEC[i][15:8]);
            if (VEC[i][31:24] < 8'h20 || VEC[i][31:24] > 8'h2C)
                check("R6 out-of-range write ignored", {7'b0, (cfg_regs == snap)}, 8'h01);
        end

        // R8: lane of 0x2C holds C3, lane of 0x23 holds 5A
        check("R8 lane 12", cfg_regs[103:96], 8'hC3);
        check("R8 lane 3", cfg_regs[31:24], 8'h5A);

        // R5: index port read and idle read give FF
        get(16'h0022, rd); check("R5 index port read", rd, 8'hFF);
        check("R5 idle rdata", io_rdata, 8'hFF);

        // R1: index holds across repeated data accesses
        put(16'h0022, 8'h2A);
        put(16'h0024, 8'h11);
        put(16'h0024, 8'h22);
        get(16'h0024, rd); check("R1 index held", rd, 8'h22);
        get(16'h0024, rd); check("R1 index held again", rd, 8'h22);

        // R9: stray addresses change neither index nor registers
        snap = cfg_regs;
        put(16'h0023, 8'h25);
        put(16'h0124, 8'hEE);
        put(16'h0025, 8'h99);
        check("R9 registers untouched", {7'b0, (cfg_regs == snap)}, 8'h01);
        get(16'h0024, rd); check("R9 index untouched", rd, 8'h22);

        // R3: index 0x21 with pattern in masked-off bits only
        put(16'h0022, 8'h21);
        put(16'h0024, 8'h0C);
        get(16'h0024, rd); check("R3 mask 0x21 zero bits", rd, 8'h00);

        // R7: back-to-back writes to 0x25 keep strobe high each following clock
        put(16'h0022, 8'h25);
        @(negedge clk);
        io_addr = 16'h0024; io_wdata = 8'h01; io_wr = 1'b1;
        @(negedge clk);
        check("R7 first pulse", {7'b0, map_update}, 8'h01);
        io_wdata = 8'h02;
        @(negedge clk);
        io_wr = 1'b0; io_addr = 16'h0;
        check("R7 second pulse", {7'b0, map_update}, 8'h01);
        @(negedge clk);
        check("R7 pulse ends", {7'b0, map_update}, 8'h00);
        check("R2 last value", cfg_regs[47:40], 8'h02);

        finish_run();
    end
endmodule